// File: doc/BRIEF.md
# Chained DMA Tag Sequencer

This block drives one source-side DMA channel from a linked list of descriptors held in memory. Each descriptor, or tag, is a 64-bit word at a 16-byte-aligned address. The sequencer reads a tag through a simple read port and decodes its operation. It may then post one transfer request, given as a start address and a quadword count, and it works out where the next tag lives. The list ends at a terminating tag, on a return with nothing stacked, or on a fault.

A two-entry return-address stack lets a list jump into a shared sub-list and resume after it. Software starts a walk with a pulse on `start_i` and the address of the first tag. It then watches `busy_o`, `done_o` and `error_o`. A one-cycle `tag_irq_o` pulse marks each tag that carries an interrupt request while interrupts are enabled. The upper half of the latest tag's command word stays visible on `tag_hi_o`.

Top module: `dma_tag_walker`

## Requirements
- R1: After reset, busy_o, done_o, error_o, tag_irq_o, fetch_req_o and xfer_valid_o are 0 and stk_level_o is 0.
- R2: A start pulse with an aligned address while idle sets busy_o and requests the tag at that address. A tag holds its address field in bits 63:32, the interrupt request in bit 31, the operation code in bits 30:28 and the quadword count N in bits 15:0. Bits 27:16 other than the request and the code do not change the walk.
- R3: Operation 1 (count) moves N quadwords from T+16, where T is the tag address, and fetches the next tag at T+16+16*N.
- R4: Operation 2 (next) moves N quadwords from T+16 and fetches the next tag at the address field.
- R5: Operations 3 (reference) and 4 (reference with stall, handled the same way) move N quadwords from the address field and fetch the next tag at T+16.
- R6: Operation 7 (end) moves N quadwords from T+16 and operation 0 moves N quadwords from the address field. Each then sets done_o and clears busy_o. done_o and error_o are never 1 together.
- R7: Operation 5 (call) moves N quadwords from T+16, pushes T+16+16*N and fetches the next tag at the address field. A call while two entries are stacked is a fault.
- R8: Operation 6 (return) moves N quadwords from T+16. It then resumes at the most recently pushed address, or ends the walk as in R6 when the stack is empty.
- R9: A start address with any of bits 3:0 set is a fault. So is an address field with any of bits 3:0 set when operations 0, 2, 3, 4 or 5 use it. A fault sets error_o, clears busy_o, and issues no transfer and no further fetch for that tag.
- R10: A tag with N = 0 posts no transfer request, and the walk carries on as its operation directs.
- R11: tag_irq_o is a one-cycle pulse in the cycle after a tag is accepted, and only when bit 31 of that tag is 1 and irq_en_i was 1 when the tag was accepted.
- R12: tag_hi_o holds bits 31:16 of the most recently accepted tag.
- R13: A start pulse while busy_o is 1 is ignored.
- R14: While xfer_valid_o is 1 and xfer_ready_i is 0, xfer_valid_o, xfer_addr_o and xfer_qwc_o stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start a walk (one-cycle pulse) |
| start_addr_i | input | 32 | Address of the first tag |
| irq_en_i | input | 1 | Tag interrupt enable |
| fetch_req_o | output | 1 | Tag read request |
| fetch_addr_o | output | 32 | Tag read address |
| fetch_valid_i | input | 1 | Tag read data valid; accepted while fetch_req_o is 1 |
| fetch_tag_i | input | 64 | Tag read data |
| xfer_valid_o | output | 1 | Transfer request valid |
| xfer_addr_o | output | 32 | Transfer start address |
| xfer_qwc_o | output | 16 | Transfer length in quadwords |
| xfer_ready_i | input | 1 | Transfer request accepted |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Last walk ended normally |
| error_o | output | 1 | Last walk ended on a fault |
| tag_irq_o | output | 1 | Tag interrupt pulse |
| tag_hi_o | output | 16 | Bits 31:16 of the latest tag |
| stk_level_o | output | 2 | Number of stacked return addresses |

## Verification
A new start request can land in the very cycle that the final transfer of a walk is handshaken. That edge both retires the walk and samples start_i. The bench provokes this by raising start_i in the cycle it asserts xfer_ready_i for the last expected transfer, and it does the same partway through a long call/return walk. It judges the outcome at the ports. done_o must rise, busy_o must fall, and the list of tag fetches must match the reference walk with no fetch from the injected address.

// File: rtl/tagwalk_pkg.sv
// Package: shared constants and types for the tag walker.
// Assumes the 64-bit tag layout the walker and its decoder both rely on.
package tagwalk_pkg;

    localparam int ADDR_W   = 32;   // byte address width
    localparam int QWC_W    = 16;   // quadword count width
    localparam int TAG_W    = 64;   // tag width
    localparam int ALIGN_W  = 4;    // low address bits that must be zero
    localparam int QW_BYTES = 16;   // bytes per quadword

    // Operation codes carried in command bits 30:28
    typedef enum logic [2:0] {
        OP_REFE = 3'd0,
        OP_CNT  = 3'd1,
        OP_NEXT = 3'd2,
        OP_REF  = 3'd3,
        OP_REFS = 3'd4,
        OP_CALL = 3'd5,
        OP_RET  = 3'd6,
        OP_END  = 3'd7
    } tag_op_e;

    // Tag layout, most significant field first
    typedef struct packed {
        logic [ADDR_W-1:0] addr;   // 63:32
        logic              irq;    // 31
        tag_op_e           op;     // 30:28
        logic [1:0]        prio;   // 27:26, not used by the walker
        logic [9:0]        rsvd;   // 25:16
        logic [QWC_W-1:0]  qwc;    // 15:0
    } tag_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_DECODE = 2'd2,
        ST_XFER   = 2'd3
    } walk_state_e;

endpackage

// File: rtl/tagwalk_stack.sv
// Module: return-address stack for call/return tags.
// Holds DEPTH addresses. The caller must not push when full or pop when empty.
// The top entry is valid only when not empty.
module tagwalk_stack #(
    parameter int DEPTH = 2,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_addr_i,
    output logic [AW-1:0] top_addr_o,
    output logic [PW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [AW-1:0] slot [DEPTH];
    logic [PW-1:0] level;

    assign full_o  = (level == PW'(DEPTH));
    assign empty_o = (level == '0);
    assign level_o = level;

    // Occupancy counter: clear on new walk, move on push or pop
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            level <= '0;
        end else if (push_i && !full_o) begin
            level <= level + 1'b1;
        end else if (pop_i && !empty_o) begin
            level <= level - 1'b1;
        end
    end

    // One storage register per entry, written when it is the next free one
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (push_i && !full_o && level == PW'(g)) begin
                slot[g] <= push_addr_i;
            end
        end
    end

    // Select the most recently pushed entry
    always_comb begin
        top_addr_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level == PW'(i + 1)) top_addr_o = slot[i];
        end
    end

    AST_STACK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);  // R7
    AST_STACK_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);  // R8

endmodule

// File: rtl/tagwalk_decode.sv
// Module: combinational decode of one fetched tag.
// From the tag, its own address and the stack state it gives the data
// address, the next tag address, halt, push/pop and fault.
// Assumes the tag address itself is already aligned.
module tagwalk_decode
    import tagwalk_pkg::*;
(
    input  tag_t              tag_i,
    input  logic [ADDR_W-1:0] tag_ptr_i,
    input  logic              stk_full_i,
    input  logic              stk_empty_i,
    input  logic [ADDR_W-1:0] stk_top_i,
    output logic [ADDR_W-1:0] data_addr_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic [ADDR_W-1:0] ret_addr_o,
    output logic              halt_o,
    output logic              push_o,
    output logic              pop_o,
    output logic              fault_o
);

    logic [ADDR_W-1:0] after_tag;
    logic [ADDR_W-1:0] after_data;
    logic              field_bad;

    // Address arithmetic shared by all operations
    always_comb begin
        after_tag  = tag_ptr_i + ADDR_W'(QW_BYTES);
        after_data = after_tag + ADDR_W'({tag_i.qwc, {ALIGN_W{1'b0}}});
        field_bad  = |tag_i.addr[ALIGN_W-1:0];
        ret_addr_o = after_data;
    end

    // Operation decode
    always_comb begin
        data_addr_o = after_tag;
        next_addr_o = after_tag;
        halt_o      = 1'b0;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        fault_o     = 1'b0;
        unique case (tag_i.op)
            OP_REFE: begin
                data_addr_o = tag_i.addr;
                halt_o      = 1'b1;
                fault_o     = field_bad;
            end
            OP_CNT: begin
                next_addr_o = after_data;
            end
            OP_NEXT: begin
                next_addr_o = tag_i.addr;
                fault_o     = field_bad;
            end
            OP_REF, OP_REFS: begin
                data_addr_o = tag_i.addr;
                fault_o     = field_bad;
            end
            OP_CALL: begin
                next_addr_o = tag_i.addr;
                fault_o     = field_bad || stk_full_i;
                push_o      = !(field_bad || stk_full_i);
            end
            OP_RET: begin
                if (!stk_empty_i) begin
                    next_addr_o = stk_top_i;
                    pop_o       = 1'b1;
                end else begin
                    halt_o = 1'b1;
                end
            end
            OP_END: begin
                halt_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dma_tag_walker.sv
// Module: top of the chained tag sequencer for one source-side channel.
// Walks the tag list: fetch, decode, optional transfer, repeat.
// Assumes fetch data is valid only while fetch_req_o is high, and that the
// transfer sink may stall with xfer_ready_i low.
module dma_tag_walker
    import tagwalk_pkg::*;
#(
    parameter int STK_DEPTH = 2,
    localparam int STK_PW   = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              irq_en_i,
    output logic              fetch_req_o,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic              fetch_valid_i,
    input  logic [TAG_W-1:0]  fetch_tag_i,
    output logic              xfer_valid_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic [QWC_W-1:0]  xfer_qwc_o,
    input  logic              xfer_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              error_o,
    output logic              tag_irq_o,
    output logic [15:0]       tag_hi_o,
    output logic [STK_PW-1:0] stk_level_o
);

    walk_state_e       state;
    tag_t              tag_q;
    logic [ADDR_W-1:0] tag_ptr;
    logic [ADDR_W-1:0] xfer_addr_q;
    logic [QWC_W-1:0]  xfer_qwc_q;
    logic              last_q;
    logic              busy_q, done_q, err_q, irq_q;
    logic [15:0]       tag_hi_q;

    logic [ADDR_W-1:0] dec_data, dec_next, dec_ret, stk_top;
    logic              dec_halt, dec_push, dec_pop, dec_fault;
    logic              stk_full, stk_empty, stk_clear;
    logic              in_decode, start_ok;

    assign in_decode = (state == ST_DECODE);
    assign start_ok  = (state == ST_IDLE) && start_i;
    assign stk_clear = start_ok;

    tagwalk_decode u_decode (
        .tag_i       (tag_q),
        .tag_ptr_i   (tag_ptr),
        .stk_full_i  (stk_full),
        .stk_empty_i (stk_empty),
        .stk_top_i   (stk_top),
        .data_addr_o (dec_data),
        .next_addr_o (dec_next),
        .ret_addr_o  (dec_ret),
        .halt_o      (dec_halt),
        .push_o      (dec_push),
        .pop_o       (dec_pop),
        .fault_o     (dec_fault)
    );

    tagwalk_stack #(.DEPTH(STK_DEPTH), .AW(ADDR_W)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (stk_clear),
        .push_i      (in_decode && dec_push),
        .pop_i       (in_decode && dec_pop),
        .push_addr_i (dec_ret),
        .top_addr_o  (stk_top),
        .level_o     (stk_level_o),
        .full_o      (stk_full),
        .empty_o     (stk_empty)
    );

    // Walk state machine with its status and tag capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            tag_q       <= '0;
            tag_ptr     <= '0;
            xfer_addr_q <= '0;
            xfer_qwc_q  <= '0;
            last_q      <= 1'b0;
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            irq_q       <= 1'b0;
            tag_hi_q    <= '0;
        end else begin
            irq_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        done_q <= 1'b0;
                        if (|start_addr_i[ALIGN_W-1:0]) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q   <= 1'b0;
                            busy_q  <= 1'b1;
                            tag_ptr <= start_addr_i;
                            state   <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_valid_i) begin
                        tag_q    <= tag_t'(fetch_tag_i);
                        tag_hi_q <= fetch_tag_i[31:16];
                        irq_q    <= irq_en_i && fetch_tag_i[31];
                        state    <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    if (dec_fault) begin
                        err_q  <= 1'b1;
                        busy_q <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        tag_ptr     <= dec_next;
                        xfer_addr_q <= dec_data;
                        xfer_qwc_q  <= tag_q.qwc;
                        last_q      <= dec_halt;
                        if (tag_q.qwc != '0) begin
                            state <= ST_XFER;
                        end else if (dec_halt) begin
                            done_q <= 1'b1;
                            busy_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_XFER: begin
                    if (xfer_ready_i) begin
                        if (last_q) begin
                            done_q <= 1'b1;
                            busy_q <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
            endcase
        end
    end

    assign fetch_req_o  = (state == ST_FETCH);
    assign fetch_addr_o = tag_ptr;
    assign xfer_valid_o = (state == ST_XFER);
    assign xfer_addr_o  = xfer_addr_q;
    assign xfer_qwc_o   = xfer_qwc_q;
    assign busy_o       = busy_q;
    assign done_o       = done_q;
    assign error_o      = err_q;
    assign tag_irq_o    = irq_q;
    assign tag_hi_o     = tag_hi_q;

    AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> fetch_addr_o[ALIGN_W-1:0] == '0);  // R9
    AST_XFER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> xfer_addr_o[ALIGN_W-1:0] == '0);  // R9
    AST_XFER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> xfer_qwc_o != '0);  // R10
    AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_qwc_o));  // R14
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));  // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tag_irq_o |-> $past(irq_en_i));  // R11
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tag_irq_o |=> !tag_irq_o);  // R11

endmodule

// File: tb/tb_dma_tag_walker.sv
module tb_dma_tag_walker;
    import tagwalk_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        irq_en_i = 1'b0;
    logic        fetch_req_o;
    logic [31:0] fetch_addr_o;
    logic        fetch_valid_i = 1'b0;
    logic [63:0] fetch_tag_i = '0;
    logic        xfer_valid_o;
    logic [31:0] xfer_addr_o;
    logic [15:0] xfer_qwc_o;
    logic        xfer_ready_i = 1'b0;
    logic        busy_o, done_o, error_o, tag_irq_o;
    logic [15:0] tag_hi_o;
    logic [1:0]  stk_level_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_tag_walker dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .irq_en_i(irq_en_i), .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
        .fetch_valid_i(fetch_valid_i), .fetch_tag_i(fetch_tag_i),
        .xfer_valid_o(xfer_valid_o), .xfer_addr_o(xfer_addr_o), .xfer_qwc_o(xfer_qwc_o),
        .xfer_ready_i(xfer_ready_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
        .tag_irq_o(tag_irq_o), .tag_hi_o(tag_hi_o), .stk_level_o(stk_level_o)
    );

    logic [63:0] mem [int unsigned];
    logic [31:0] exp_f[$], act_f[$];
    logic [47:0] exp_x[$], act_x[$];
    bit          exp_done, exp_err;
    int          exp_irq;
    logic [15:0] exp_hi;

    int  n_checks = 0, n_bad = 0;
    int  cyc_all = 0, run_cyc = 0, irq_cnt = 0, maxlvl = 0;
    bit  timeout = 0, req_start = 0, inj_mid = 0, inj_last = 0;
    logic [31:0] req_addr = '0;

    function automatic logic [63:0] mk(logic [2:0] op, logic irq, logic [15:0] n, logic [31:0] a);
        return {a, irq, op, 2'b10, 10'h0, n};
    endfunction

    function automatic logic [63:0] mem_rd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return mk(3'd7, 1'b0, 16'd0, 32'd0);
    endfunction

    // Reference walk computed from the requirements
    function automatic void model(logic [31:0] s, bit tie);
        logic [31:0] t, nxt, dat, a;
        logic [31:0] stk [2];
        int          d;
        logic [63:0] tg;
        logic [15:0] n;
        bit          halt, bad;
        exp_f.delete(); exp_x.delete();
        exp_done = 0; exp_err = 0; exp_irq = 0; exp_hi = '0;
        if (s[3:0] != 0) begin exp_err = 1; return; end
        t = s; d = 0;
        for (int k = 0; k < 64; k++) begin
            exp_f.push_back(t);
            tg = mem_rd(t);
            if (tg[31] && tie) exp_irq++;
            exp_hi = tg[31:16];
            a = tg[63:32]; n = tg[15:0];
            dat = t + 16; nxt = t + 16; halt = 0; bad = 0;
            case (tg[30:28])
                3'd0: begin dat = a; halt = 1; bad = (a[3:0] != 0); end
                3'd1: nxt = t + 16 + {12'd0, n, 4'd0};
                3'd2: begin nxt = a; bad = (a[3:0] != 0); end
                3'd3, 3'd4: begin dat = a; bad = (a[3:0] != 0); end
                3'd5: begin
                    bad = (d == 2) || (a[3:0] != 0);
                    if (!bad) begin stk[d] = t + 16 + {12'd0, n, 4'd0}; d++; nxt = a; end
                end
                3'd6: if (d > 0) begin d--; nxt = stk[d]; end else halt = 1;
                default: halt = 1;
            endcase
            if (bad) begin exp_err = 1; return; end
            if (n != 0) exp_x.push_back({dat, n});
            if (halt) begin exp_done = 1; return; end
            t = nxt;
        end
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // One cycle: sample at the falling edge, then drive for the next rising edge
    task automatic tick();
        @(negedge clk);
        cyc_all++;
        if (cyc_all > WD_LIMIT) timeout = 1;
        if (tag_irq_o) irq_cnt++;
        if (int'(stk_level_o) > maxlvl) maxlvl = int'(stk_level_o);
        start_i = 1'b0;
        if (req_start) begin start_i = 1'b1; start_addr_i = req_addr; req_start = 0; end
        fetch_valid_i = fetch_req_o && ($urandom % 3 != 0);
        fetch_tag_i   = mem_rd(fetch_addr_o);
        if (fetch_valid_i) act_f.push_back(fetch_addr_o);
        xfer_ready_i = ($urandom % 4 != 0);
        if (xfer_valid_o && xfer_ready_i) begin
            act_x.push_back({xfer_addr_o, xfer_qwc_o});
            if (inj_last && act_x.size() == exp_x.size()) begin
                start_i = 1'b1; start_addr_i = 32'h40;
            end
        end
        if (inj_mid && run_cyc == 3) begin start_i = 1'b1; start_addr_i = 32'h40; end
        run_cyc++;
    endtask

    task automatic run_chain(logic [31:0] s, bit tie, string lbl);
        bit same;
        model(s, tie);
        act_f.delete(); act_x.delete();
        irq_cnt = 0; maxlvl = 0; run_cyc = 0;
        irq_en_i = tie;
        req_start = 1; req_addr = s;
        tick();
        tick();
        while (busy_o && !timeout) tick();
        repeat (3) tick();
        inj_mid = 0; inj_last = 0;
        same = (act_f.size() == exp_f.size());
        if (same) foreach (exp_f[i]) if (act_f[i] != exp_f[i]) same = 0;
        check(same, "R2", "fetch list size", 64'(act_f.size()), 64'(exp_f.size()));
        same = (act_x.size() == exp_x.size());
        if (same) foreach (exp_x[i]) if (act_x[i] != exp_x[i]) same = 0;
        check(same, lbl, "transfer list {addr,qwc} count",
              64'(act_x.size()), 64'(exp_x.size()));
        check(done_o == exp_done, exp_err ? "R9" : "R6", "done", 64'(done_o), 64'(exp_done));
        check(error_o == exp_err, exp_err ? "R9" : lbl, "error", 64'(error_o), 64'(exp_err));
        check(!busy_o, lbl, "busy after walk", 64'(busy_o), 64'd0);
        check(irq_cnt == exp_irq, "R11", "irq pulses", 64'(irq_cnt), 64'(exp_irq));
        if (exp_f.size() > 0)
            check(tag_hi_o == exp_hi, "R12", "tag_hi", 64'(tag_hi_o), 64'(exp_hi));
    endtask

    // Random forward-only list; last tag ends it, address fields sometimes misaligned
    task automatic build_random(logic [31:0] base);
        logic [31:0] t, a, da;
        logic [15:0] n;
        logic [2:0]  op;
        int          len;
        t = base;
        len = 1 + int'($urandom % 7);
        for (int i = 0; i < len; i++) begin
            n  = 16'($urandom % 4);
            da = base + 32'h8000 + 32'(($urandom % 256) * 16);
            if ($urandom % 10 == 0) da = da | 32'h8;
            if (i == len - 1) begin
                case ($urandom % 3)
                    0: op = 3'd7;
                    1: op = 3'd0;
                    default: op = 3'd6;
                endcase
                mem[t] = mk(op, 1'($urandom), n, da);
            end else begin
                case ($urandom % 4)
                    0: begin op = 3'd1; mem[t] = mk(op, 1'($urandom), n, 32'h0); t = t + 16 + {12'd0, n, 4'd0}; end
                    1: begin
                        a = t + 32'h400;
                        if ($urandom % 10 == 0) a = a | 32'h4;
                        mem[t] = mk(3'd2, 1'($urandom), n, a); t = a;
                    end
                    2: begin mem[t] = mk(3'd3, 1'($urandom), n, da); t = t + 16; end
                    default: begin mem[t] = mk(3'd4, 1'($urandom), n, da); t = t + 16; end
                endcase
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !error_o && !tag_irq_o, "R1", "status after reset",
              {60'd0, busy_o, done_o, error_o, tag_irq_o}, 64'd0);
        check(!fetch_req_o && !xfer_valid_o && stk_level_o == 0, "R1", "requests after reset",
              {61'd0, fetch_req_o, xfer_valid_o, |stk_level_o}, 64'd0);

        // R3: count then end; end handshake coincides with a start request (R13)
        mem[32'h100] = mk(3'd1, 1'b1, 16'd2, 32'h0);
        mem[32'h130] = mk(3'd7, 1'b1, 16'd1, 32'h0);
        inj_last = 1;
        run_chain(32'h100, 1'b1, "R3");

        // R4: next jumps to the address field
        mem[32'hD00] = mk(3'd2, 1'b0, 16'd2, 32'hE00);
        mem[32'hE00] = mk(3'd7, 1'b0, 16'd0, 32'h0);
        run_chain(32'hD00, 1'b1, "R4");

        // R5 and R6: reference, stall reference, reference-then-end
        mem[32'h400] = mk(3'd3, 1'b1, 16'd3, 32'h2000);
        mem[32'h410] = mk(3'd4, 1'b0, 16'd1, 32'h2400);
        mem[32'h420] = mk(3'd0, 1'b1, 16'd5, 32'h3000);
        run_chain(32'h400, 1'b1, "R5");

        // R8: nested call/return with zero-length tags (R10)
        mem[32'h500] = mk(3'd5, 1'b0, 16'd1, 32'h600);
        mem[32'h600] = mk(3'd5, 1'b1, 16'd0, 32'h700);
        mem[32'h700] = mk(3'd6, 1'b0, 16'd2, 32'h0);
        mem[32'h610] = mk(3'd6, 1'b0, 16'd0, 32'h0);
        mem[32'h520] = mk(3'd6, 1'b0, 16'd1, 32'h0);
        run_chain(32'h500, 1'b1, "R8");
        check(maxlvl == 2, "R7", "peak stack level", 64'(maxlvl), 64'd2);

        // R13: same walk with a start pulse partway through
        inj_mid = 1;
        run_chain(32'h500, 1'b0, "R13");

        // R7: third nested call overflows the stack
        mem[32'h800] = mk(3'd5, 1'b0, 16'd1, 32'h900);
        mem[32'h900] = mk(3'd5, 1'b0, 16'd1, 32'hA00);
        mem[32'hA00] = mk(3'd5, 1'b0, 16'd1, 32'hB00);
        run_chain(32'h800, 1'b0, "R7");

        // R9: misaligned reference address, then misaligned start
        mem[32'hC00] = mk(3'd3, 1'b1, 16'd4, 32'h2008);
        run_chain(32'hC00, 1'b1, "R9");
        run_chain(32'h104, 1'b1, "R9");

        // R10: zero-length count then zero-length end
        mem[32'hF00] = mk(3'd1, 1'b0, 16'd0, 32'h0);
        mem[32'hF10] = mk(3'd7, 1'b0, 16'd0, 32'h0);
        run_chain(32'hF00, 1'b1, "R10");

        // R11: request bits set but interrupts disabled
        run_chain(32'h400, 1'b0, "R11");

        // R14: random lists under random back-pressure
        for (int k = 0; k < 30 && !timeout; k++) begin
            build_random(32'h100000 + 32'(k) * 32'h10000);
            inj_last = 1'($urandom);
            run_chain(32'h100000 + 32'(k) * 32'h10000, 1'($urandom), "R14");
        end

        if (timeout) check(1'b0, "R1", "watchdog expired", 64'(cyc_all), 64'(WD_LIMIT));
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule